// File: doc/BRIEF.md
# Multiprocessor Interrupt and Arbitration Status Word

This block keeps one 64-bit control and status word that up to four processors share. For each processor it holds one pending bit for interprocessor interrupts and one for interval timer interrupts. It also holds two small fields that track bus arbitration trouble, and a 4-bit general read/write field. Each field obeys its own write rule: write-one-to-clear, write-one-to-set, set-only-while-empty, or plain overwrite.

Software posts an interprocessor interrupt by writing ones into a request field. Those ones set the matching pending bits, and the request field itself is never stored. A timer pulse per processor sets that processor's timer bit. The block drives one interprocessor and one timer interrupt line per processor straight from the stored bits. A read names the requesting processor, and the returned word carries that processor's index in its two lowest bits.

Top module: `misc_irq_ctl`

## Requirements
- R1: After synchronous reset every stored bit is 0, `ipi_irq` and `iti_irq` are 0, and `rd_data` is 0.
- R2: On a write, each 1 in `wr_data[11:4]` clears the stored bit at the same position. Bits 7:4 are the timer pending bits for processors 0..3 and bits 11:8 are the interprocessor pending bits for processors 0..3.
- R3: On a write, a 1 in `wr_data[12+i]` sets interprocessor pending bit 8+i. It wins over a clear of bit 8+i in the same write. Bits 15:12 are not stored and read as 0.
- R4: `tmr_set[i]` high on a clock edge sets timer pending bit 4+i. It wins over a clear of that bit by a write on the same edge.
- R5: A write with `wr_data[20]`=1 clears both arbitration fields (bits 23:16). Nothing in that write sets either field.
- R6: A write with `wr_data[20]`=0 ORs `wr_data[23:21]` into stored bits 23:21. Stored bit 20 always reads 0.
- R7: Arbitration field bits 19:16 take `wr_data[19:16]` on a write with `wr_data[20]`=0, but only while the stored field is 0000. While the field is nonzero such writes leave it unchanged.
- R8: Bits 43:40 are overwritten with `wr_data[43:40]` on every write.
- R9: When `rd_en` is high on an edge, `rd_data` takes the word as it stood before that edge, with bits 1:0 set to `rd_id`. All bits not named in R2..R8 are 0. `rd_data` holds its value while `rd_en` is low.
- R10: `ipi_irq[i]` equals stored bit 8+i and `iti_irq[i]` equals stored bit 4+i. Both are visible in the cycle after the edge that updates the bits. A timer line can fall only through a write clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 64 | Write value |
| tmr_set | input | 4 | Per-processor timer pulse |
| rd_en | input | 1 | Read strobe |
| rd_id | input | 2 | Index of the reading processor |
| rd_data | output | 64 | Registered read word |
| ipi_irq | output | 4 | Interprocessor interrupt lines |
| iti_irq | output | 4 | Interval timer interrupt lines |

## Verification
Two pairs of events can land on the same edge. The first is a timer pulse and a write that clears the same timer bit. The second is a write that both clears and requests the same interprocessor bit. The bench drives each collision with one combined stimulus and expects the setting side to win in both cases. A read on the same edge as a write is also provoked, and it must return the word from before the write. A behavioural reference model of the word is compared with every output on every clock.

// File: rtl/misc_irq_pkg.sv
package misc_irq_pkg;
    localparam int DATA_W   = 64;
    localparam int MAX_CPU  = 4;
    localparam int ID_W     = 2;
    localparam int ITI_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int REQ_LSB  = 12;
    localparam int WIN_LSB  = 16;
    localparam int WIN_W    = 4;
    localparam int WIPE_BIT = 20;
    localparam int TRK_LSB  = 21;
    localparam int TRK_W    = 3;
    localparam int USR_LSB  = 40;
    localparam int USR_W    = 4;

    typedef struct packed {
        logic [MAX_CPU-1:0] iti_clr;
        logic [MAX_CPU-1:0] ipi_clr;
        logic [MAX_CPU-1:0] ipi_req;
        logic               wipe;
        logic [WIN_W-1:0]   win_set;
        logic [TRK_W-1:0]   trk_set;
        logic [USR_W-1:0]   usr_val;
    } wr_cmd_t;

    function automatic logic [DATA_W-1:0] merge_id(input logic [DATA_W-1:0] img,
                                                   input logic [ID_W-1:0] id);
        return img | {{(DATA_W-ID_W){1'b0}}, id};
    endfunction
endpackage

// File: rtl/misc_cpu_lane.sv
module misc_cpu_lane (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic clr_iti,
    input  logic clr_ipi,
    input  logic req_ipi,
    input  logic tmr_set,
    output logic iti_q,
    output logic ipi_q
);
    logic iti_d;
    logic ipi_d;

    always_comb begin
        iti_d = iti_q;
        ipi_d = ipi_q;
        if (wr_en) begin
            if (clr_iti) iti_d = 1'b0;
            if (clr_ipi) ipi_d = 1'b0;
            if (req_ipi) ipi_d = 1'b1;
        end
        if (tmr_set) iti_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iti_q <= 1'b0;
            ipi_q <= 1'b0;
        end else begin
            iti_q <= iti_d;
            ipi_q <= ipi_d;
        end
    end
endmodule

// File: rtl/misc_arb_track.sv
module misc_arb_track
    import misc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wipe,
    input  logic [WIN_W-1:0] win_set,
    input  logic [TRK_W-1:0] trk_set,
    output logic [WIN_W-1:0] win_q,
    output logic [TRK_W-1:0] trk_q
);
    logic [WIN_W-1:0] win_d;
    logic [TRK_W-1:0] trk_d;
    logic             win_empty;

    assign win_empty = (win_q == '0);

    always_comb begin
        win_d = win_q;
        trk_d = trk_q;
        if (wr_en) begin
            if (wipe) begin
                win_d = '0;
                trk_d = '0;
            end else begin
                trk_d = trk_q | trk_set;
                if (win_empty) win_d = win_set;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            trk_q <= '0;
        end else begin
            win_q <= win_d;
            trk_q <= trk_d;
        end
    end
endmodule

// File: rtl/misc_rd_port.sv
module misc_rd_port
    import misc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [DATA_W-1:0] image,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else if (rd_en) rd_data <= merge_id(image, rd_id);
    end
endmodule

// File: rtl/misc_irq_ctl.sv
module misc_irq_ctl
    import misc_irq_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [63:0]        wr_data,
    input  logic [NUM_CPU-1:0] tmr_set,
    input  logic               rd_en,
    input  logic [1:0]         rd_id,
    output logic [63:0]        rd_data,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] iti_irq
);
    wr_cmd_t           cmd;
    logic [WIN_W-1:0]  arb_win;
    logic [TRK_W-1:0]  arb_trk;
    logic [USR_W-1:0]  usr_q;
    logic [DATA_W-1:0] image;
    logic              unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        cmd         = '0;
        cmd.iti_clr = wr_data[ITI_LSB +: MAX_CPU];
        cmd.ipi_clr = wr_data[IPI_LSB +: MAX_CPU];
        cmd.ipi_req = wr_data[REQ_LSB +: MAX_CPU];
        cmd.wipe    = wr_data[WIPE_BIT];
        cmd.win_set = wr_data[WIN_LSB +: WIN_W];
        cmd.trk_set = wr_data[TRK_LSB +: TRK_W];
        cmd.usr_val = wr_data[USR_LSB +: USR_W];
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_lane
        misc_cpu_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .clr_iti (cmd.iti_clr[i]),
            .clr_ipi (cmd.ipi_clr[i]),
            .req_ipi (cmd.ipi_req[i]),
            .tmr_set (tmr_set[i]),
            .iti_q   (iti_irq[i]),
            .ipi_q   (ipi_irq[i])
        );
    end

    misc_arb_track u_arb (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wipe    (cmd.wipe),
        .win_set (cmd.win_set),
        .trk_set (cmd.trk_set),
        .win_q   (arb_win),
        .trk_q   (arb_trk)
    );

    always_ff @(posedge clk) begin
        if (rst) usr_q <= '0;
        else if (wr_en) usr_q <= cmd.usr_val;
    end

    always_comb begin
        image = '0;
        image[ITI_LSB +: NUM_CPU] = iti_irq;
        image[IPI_LSB +: NUM_CPU] = ipi_irq;
        image[WIN_LSB +: WIN_W]   = arb_win;
        image[TRK_LSB +: TRK_W]   = arb_trk;
        image[USR_LSB +: USR_W]   = usr_q;
    end

    misc_rd_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_id   (rd_id),
        .image   (image),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/misc_irq_ctl_chk.sv
module misc_irq_ctl_chk #(
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [63:0]        wr_data,
    input logic [NUM_CPU-1:0] tmr_set,
    input logic               rd_en,
    input logic [1:0]         rd_id,
    input logic [63:0]        rd_data,
    input logic [NUM_CPU-1:0] ipi_irq,
    input logic [NUM_CPU-1:0] iti_irq,
    input logic [3:0]         arb_win,
    input logic [2:0]         arb_trk,
    input logic [3:0]         usr_q
);
    logic unused_chk;
    assign unused_chk = ^{wr_data, rd_data};

    // R3
    a_r3_req_sets_ipi: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ipi_irq & $past(wr_data[12 +: NUM_CPU])) == $past(wr_data[12 +: NUM_CPU])));
    // R2
    a_r2_ipi_clear: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ipi_irq & $past(wr_data[8 +: NUM_CPU]) & ~$past(wr_data[12 +: NUM_CPU])) == '0));
    // R4
    a_r4_timer_sets: assert property (@(posedge clk) disable iff (rst)
        (|tmr_set) |=> ((iti_irq & $past(tmr_set)) == $past(tmr_set)));
    // R10
    a_r10_iti_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (iti_irq == ($past(iti_irq) | $past(tmr_set))));
    // R5
    a_r5_wipe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[20]) |=> (arb_win == 4'd0 && arb_trk == 3'd0));
    // R7
    a_r7_win_locked: assert property (@(posedge clk) disable iff (rst)
        (arb_win != 4'd0 && !(wr_en && wr_data[20])) |=> $stable(arb_win));
    // R8
    a_r8_usr_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (usr_q == $past(wr_data[43:40])));
    // R9
    a_r9_rd_id: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data[1:0] == $past(rd_id)));
endmodule

bind misc_irq_ctl misc_irq_ctl_chk #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tmr_set (tmr_set),
    .rd_en   (rd_en),
    .rd_id   (rd_id),
    .rd_data (rd_data),
    .ipi_irq (ipi_irq),
    .iti_irq (iti_irq),
    .arb_win (arb_win),
    .arb_trk (arb_trk),
    .usr_q   (usr_q)
);

// File: tb/misc_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module misc_irq_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [3:0]  tmr_set = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_id = '0;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [3:0]  iti_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit [63:0] m_word = '0;
    bit [63:0] m_rd = '0;

    always #2 clk = ~clk;

    misc_irq_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tmr_set(tmr_set), .rd_en(rd_en), .rd_id(rd_id),
        .rd_data(rd_data), .ipi_irq(ipi_irq), .iti_irq(iti_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: field by field from the requirements
    always @(posedge clk) begin
        bit [63:0] nxt;
        if (rst) begin
            m_word = '0;
            m_rd   = '0;
        end else begin
            if (rd_en) m_rd = m_word | {62'd0, rd_id};
            nxt = m_word;
            if (wr_en) begin
                for (int b = 4; b < 12; b++) if (wr_data[b]) nxt[b] = 1'b0;
                if (wr_data[20]) begin
                    for (int b = 16; b < 24; b++) nxt[b] = 1'b0;
                end else begin
                    for (int b = 21; b < 24; b++) if (wr_data[b]) nxt[b] = 1'b1;
                    if (m_word[19:16] == 4'd0) nxt[19:16] = wr_data[19:16];
                end
                for (int c = 0; c < 4; c++) if (wr_data[12+c]) nxt[8+c] = 1'b1;
                nxt[43:40] = wr_data[43:40];
            end
            for (int c = 0; c < 4; c++) if (tmr_set[c]) nxt[4+c] = 1'b1;
            m_word = nxt;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 ipi lines", {60'd0, ipi_irq}, {60'd0, m_word[11:8]});
            chk("R10 iti lines", {60'd0, iti_irq}, {60'd0, m_word[7:4]});
            chk("R9 read word", rd_data, m_rd);
        end
    end

    task automatic put(input logic [63:0] d, input logic [3:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; tmr_set = t;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; tmr_set = '0;
    endtask

    task automatic pulse(input logic [3:0] t);
        @(negedge clk);
        tmr_set = t;
        @(negedge clk);
        tmr_set = '0;
    endtask

    task automatic get(input logic [1:0] id, input logic [63:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_id = id;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data after reset", rd_data, 64'h0);
        chk("R1 lines after reset", {56'd0, ipi_irq, iti_irq}, 64'h0);
        rst = 1'b0;
        get(2'd2, 64'h2, "R1 empty word read");

        pulse(4'b0101);
        chk("R4 timer lines", {60'd0, iti_irq}, 64'h5);
        get(2'd0, 64'h50, "R4 timer bits");

        put(64'h0000_F000, 4'b0);
        chk("R3 ipi lines", {60'd0, ipi_irq}, 64'hF);
        get(2'd0, 64'hF50, "R3 request sets pending, not stored");

        put(64'h0000_0110, 4'b0);
        get(2'd1, 64'hE41, "R2 write-one clear");

        put(64'h0000_0040, 4'b0100);
        get(2'd3, 64'hE43, "R4 timer wins over clear");

        put(64'h0000_1100, 4'b0);
        get(2'd0, 64'hF40, "R3 request wins over clear");

        put(64'h0005_0000, 4'b0);
        get(2'd0, 64'h5_0F40, "R7 set while empty");
        put(64'h0003_0000, 4'b0);
        get(2'd0, 64'h5_0F40, "R7 ignored while nonzero");

        put(64'h00E0_0000, 4'b0);
        get(2'd0, 64'hE5_0F40, "R6 track field or-in");

        put(64'h00F3_0000, 4'b0);
        get(2'd0, 64'hF40, "R5 wipe clears both fields");

        put(64'h0002_0000, 4'b0);
        get(2'd0, 64'h2_0F40, "R7 writable after wipe");

        put(64'h0000_0A00_0000_0000, 4'b0);
        get(2'd0, 64'h0000_0A00_0002_0F40, "R8 user field write");
        put(64'h0, 4'b0);
        get(2'd0, 64'h2_0F40, "R8 user field overwrite");

        put(64'hFFFF_FFFF_FFFF_FFFF, 4'b0);
        get(2'd1, 64'h0000_0F00_0000_0F01, "R9 unnamed bits read zero");
        chk("R10 iti dropped by clear", {60'd0, iti_irq}, 64'h0);

        @(negedge clk);
        rd_en = 1'b1; rd_id = 2'd2; wr_en = 1'b1; wr_data = 64'h0000_0000_0000_0F00;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R9 read sees word before write", rd_data, 64'h0000_0F00_0000_0F02);
        @(negedge clk);
        chk("R9 read holds", rd_data, 64'h0000_0F00_0000_0F02);
        chk("R10 ipi cleared", {60'd0, ipi_irq}, 64'h0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears word", rd_data, 64'h0);
        rst = 1'b0;
        get(2'd3, 64'h3, "R1 word empty after second reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule